// File: doc/BRIEF.md
# Four-bit arithmetic-logic unit with status flags

This block is a purely combinational arithmetic-logic unit. It takes two unsigned 4-bit operands and a 3-bit operation code. From these it produces a 4-bit result and three status flags. The flags are a zero indicator, a carry/borrow indicator and a signed-overflow indicator. A surrounding datapath drives the operands and the code. Within the same cycle it reads back the result and the flags. The block holds no state, and the outputs follow the inputs after combinational delay only.

Five operation codes are defined: two arithmetic and three bitwise. The remaining three codes force the result to zero and clear the carry and overflow flags. Every output gets a default value before the operation code is decoded, so the block infers no storage.

Top module: `alu_core`

## Requirements
- R1: Code 3'b000 gives result = (a + b) modulo 16.
- R2: Code 3'b001 gives result = (a - b) modulo 16.
- R3: Code 3'b010 gives bitwise a AND b, code 3'b011 gives bitwise a OR b, and code 3'b100 gives bitwise a XOR b.
- R4: Codes 3'b101, 3'b110 and 3'b111 give result 0 whatever the operand values are.
- R5: The zero flag is 1 exactly when the 4-bit result is 0. This includes the zero result of the codes in R4.
- R6: On code 3'b000 the carry flag equals the carry out of the unsigned 4-bit addition. On code 3'b001 it is 1 exactly when a < b as unsigned numbers (borrow).
- R7: The carry flag is 0 for the three bitwise codes and for the codes in R4.
- R8: On code 3'b000 the overflow flag is 1 exactly when a[3] equals b[3] and result[3] differs from a[3].
- R9: On code 3'b001 the overflow flag is 1 exactly when a[3] differs from b[3] and result[3] differs from a[3].
- R10: The overflow flag is 0 for every code other than 3'b000 and 3'b001.
- R11: When all inputs are known (no X or Z), every output is known. The block holds no value from an earlier input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 4 | First operand (minuend for subtraction) |
| b_i | input | 4 | Second operand (subtrahend for subtraction) |
| opcode_i | input | 3 | Operation select |
| result_o | output | 4 | Operation result |
| zero_o | output | 1 | Result equals zero |
| carry_o | output | 1 | Carry out for add, borrow for subtract |
| ovf_o | output | 1 | Signed overflow for add and subtract |

## Verification
The block has no state, so a wrong internal value appears at the ports within the same evaluation as the input that exposes it. Nothing can stay hidden until a later cycle. An inferred hold element would show up as an unknown output, or as a value left over from the previous vector. The bench detects this on the very next input change. A decode fault, such as a swapped select or a missed unused code, corrupts the result or a flag only for the codes it touches. For that reason every operand pair is applied under every code, so that each code is checked against the full set of inputs.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int unsigned DATA_W = 4;
  localparam int unsigned OP_W   = 3;

  localparam logic [OP_W-1:0] OPC_ADD = 3'b000;
  localparam logic [OP_W-1:0] OPC_SUB = 3'b001;
  localparam logic [OP_W-1:0] OPC_AND = 3'b010;
  localparam logic [OP_W-1:0] OPC_OR  = 3'b011;
  localparam logic [OP_W-1:0] OPC_XOR = 3'b100;

  // bitwise sub-select handed to the logic unit
  typedef enum logic [1:0] {
    LSEL_AND = 2'd0,
    LSEL_OR  = 2'd1,
    LSEL_XOR = 2'd2
  } lsel_e;

  // decoded operation class
  typedef enum logic [1:0] {
    KIND_ARITH = 2'd0,
    KIND_LOGIC = 2'd1,
    KIND_NONE  = 2'd2
  } kind_e;
endpackage

// File: rtl/alu_arith.sv
module alu_arith #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         cb_o,
  output logic         ovf_o
);
  localparam int unsigned MSB = W - 1;

  // extended adder with carry in
  function automatic logic [W:0] add_ext(input logic [W-1:0] x,
                                         input logic [W-1:0] y,
                                         input logic         cin);
    add_ext = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
  endfunction

  // two's complement overflow: like-signed inputs, differently signed sum
  function automatic logic sign_flip(input logic xs, input logic ys, input logic rs);
    sign_flip = (xs == ys) && (rs != xs);
  endfunction

  logic [W-1:0] b_eff;
  logic [W:0]   ext;
  logic         cout_raw;

  always_comb begin
    b_eff    = sub_i ? ~b_i : b_i;
    ext      = add_ext(a_i, b_eff, sub_i);
    sum_o    = ext[W-1:0];
    cout_raw = ext[W];
    // subtract: carry out of a + ~b + 1 is the inverse of borrow
    cb_o     = sub_i ? ~cout_raw : cout_raw;
    ovf_o    = sign_flip(a_i[MSB], b_eff[MSB], sum_o[MSB]);
  end
endmodule

// File: rtl/alu_logic.sv
module alu_logic
  import alu_pkg::*;
#(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  lsel_e        sel_i,
  output logic [W-1:0] out_o
);
  for (genvar k = 0; k < W; k++) begin : g_bit
    always_comb begin
      out_o[k] = 1'b0;
      unique case (sel_i)
        LSEL_AND: out_o[k] = a_i[k] & b_i[k];
        LSEL_OR:  out_o[k] = a_i[k] | b_i[k];
        LSEL_XOR: out_o[k] = a_i[k] ^ b_i[k];
        default:  out_o[k] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/alu_flags.sv
module alu_flags #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] result_i,
  output logic         zero_o
);
  always_comb begin
    zero_o = ~|result_i;
  end
endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int unsigned W  = DATA_W,
  parameter int unsigned OW = OP_W
) (
  input  logic [W-1:0]  a_i,
  input  logic [W-1:0]  b_i,
  input  logic [OW-1:0] opcode_i,
  output logic [W-1:0]  result_o,
  output logic          zero_o,
  output logic          carry_o,
  output logic          ovf_o
);
  // decode, brought out as named wires
  kind_e        kind;
  lsel_e        lsel;
  logic         is_sub;
  logic         is_add;

  always_comb begin
    kind   = KIND_NONE;
    lsel   = LSEL_AND;
    is_sub = 1'b0;
    is_add = 1'b0;
    case (opcode_i)
      OPC_ADD: begin kind = KIND_ARITH; is_add = 1'b1; end
      OPC_SUB: begin kind = KIND_ARITH; is_sub = 1'b1; end
      OPC_AND: begin kind = KIND_LOGIC; lsel = LSEL_AND; end
      OPC_OR:  begin kind = KIND_LOGIC; lsel = LSEL_OR;  end
      OPC_XOR: begin kind = KIND_LOGIC; lsel = LSEL_XOR; end
      default: kind = KIND_NONE;
    endcase
  end

  logic [W-1:0] arith_sum;
  logic         arith_cb;
  logic         arith_ovf;
  logic [W-1:0] logic_out;

  alu_arith #(.W(W)) u_arith (
    .a_i   (a_i),
    .b_i   (b_i),
    .sub_i (is_sub),
    .sum_o (arith_sum),
    .cb_o  (arith_cb),
    .ovf_o (arith_ovf)
  );

  alu_logic #(.W(W)) u_logic (
    .a_i   (a_i),
    .b_i   (b_i),
    .sel_i (lsel),
    .out_o (logic_out)
  );

  // output select; every output gets a default first
  always_comb begin
    result_o = '0;
    carry_o  = 1'b0;
    ovf_o    = 1'b0;
    case (kind)
      KIND_ARITH: begin
        result_o = arith_sum;
        carry_o  = arith_cb;
        ovf_o    = arith_ovf;
      end
      KIND_LOGIC: result_o = logic_out;
      default:    result_o = '0;
    endcase
  end

  alu_flags #(.W(W)) u_flags (
    .result_i (result_o),
    .zero_o   (zero_o)
  );

  // checks next to the select logic
  always_comb begin
    if (!$isunknown({a_i, b_i, opcode_i})) begin
      if (is_add)
        a_r1_add_sum: assert (result_o == W'(a_i + b_i));
      if (opcode_i > OPC_XOR)
        a_r4_undef_zero: assert (result_o == '0);
      if (is_sub)
        a_r6_sub_borrow: assert (carry_o == (a_i < b_i));
      if (kind == KIND_LOGIC || kind == KIND_NONE)
        a_r7_no_carry: assert (!carry_o);
      if (!(is_add || is_sub))
        a_r10_no_overflow: assert (!ovf_o);
      a_r11_known: assert (!$isunknown({result_o, zero_o, carry_o, ovf_o}));
    end
  end
endmodule

// File: tb/alu_core_tb_top.sv
module alu_core_tb_top;
  localparam int W  = 4;
  localparam int OW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk; // 200 MHz

  logic [W-1:0]  a, b;
  logic [OW-1:0] op;
  logic [W-1:0]  res;
  logic          zf, cf, vf;

  alu_core dut_i (
    .a_i(a), .b_i(b), .opcode_i(op),
    .result_o(res), .zero_o(zf), .carry_o(cf), .ovf_o(vf)
  );

  typedef struct {
    logic [W-1:0]  a, b;
    logic [OW-1:0] op;
    logic [W-1:0]  r;
    logic          z, c, v;
  } exp_t;

  exp_t q[$];
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // model from the requirement text
  function automatic exp_t model(input logic [W-1:0] x, input logic [W-1:0] y,
                                 input logic [OW-1:0] o);
    exp_t e;
    logic [W:0] full;
    e.a = x; e.b = y; e.op = o;
    e.r = '0; e.c = 1'b0; e.v = 1'b0;
    case (o)
      3'b000: begin
        full = {1'b0, x} + {1'b0, y};
        e.r = full[W-1:0];
        e.c = full[W];
        e.v = (x[W-1] == y[W-1]) && (e.r[W-1] != x[W-1]);
      end
      3'b001: begin
        e.r = x - y;
        e.c = (x < y);
        e.v = (x[W-1] != y[W-1]) && (e.r[W-1] != x[W-1]);
      end
      3'b010: e.r = x & y;
      3'b011: e.r = x | y;
      3'b100: e.r = x ^ y;
      default: e.r = '0;
    endcase
    e.z = (e.r == '0);
    return e;
  endfunction

  function automatic string res_tag(input logic [OW-1:0] o);
    case (o)
      3'b000: return "R1";
      3'b001: return "R2";
      3'b010, 3'b011, 3'b100: return "R3";
      default: return "R4";
    endcase
  endfunction

  function automatic string c_tag(input logic [OW-1:0] o);
    return (o <= 3'b001) ? "R6" : "R7";
  endfunction

  function automatic string v_tag(input logic [OW-1:0] o);
    case (o)
      3'b000: return "R8";
      3'b001: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic drive(input logic [W-1:0] x, input logic [W-1:0] y,
                       input logic [OW-1:0] o);
    @(negedge clk);
    a = x; b = y; op = o;
    q.push_back(model(x, y, o));
  endtask

  // monitor: inputs set at negedge, outputs read at following posedge
  always @(posedge clk) begin
    if (rst_n && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_chk++;
      if ($isunknown({res, zf, cf, vf})) begin
        n_fail++;
        $display("FAIL R11 a=%h b=%h op=%b outputs=%b%b%b%b expected known",
                 e.a, e.b, e.op, res, zf, cf, vf);
      end
      n_chk++;
      if (res !== e.r) begin
        n_fail++;
        $display("FAIL %s a=%h b=%h op=%b result=%h expected %h",
                 res_tag(e.op), e.a, e.b, e.op, res, e.r);
      end
      n_chk++;
      if (zf !== e.z) begin
        n_fail++;
        $display("FAIL R5 a=%h b=%h op=%b zero=%b expected %b",
                 e.a, e.b, e.op, zf, e.z);
      end
      n_chk++;
      if (cf !== e.c) begin
        n_fail++;
        $display("FAIL %s a=%h b=%h op=%b carry=%b expected %b",
                 c_tag(e.op), e.a, e.b, e.op, cf, e.c);
      end
      n_chk++;
      if (vf !== e.v) begin
        n_fail++;
        $display("FAIL %s a=%h b=%h op=%b ovf=%b expected %b",
                 v_tag(e.op), e.a, e.b, e.op, vf, e.v);
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired with %0d items pending", q.size());
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    a = '0; b = '0; op = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // reset-state vector: zero inputs add, expect 0 with zero flag (R1, R5)
    drive(4'h0, 4'h0, 3'b000);
    // corner cases: R8 positive overflow, R6 carry, R9 overflow, R6 borrow
    drive(4'h7, 4'h1, 3'b000);
    drive(4'hF, 4'h1, 3'b000);
    drive(4'h8, 4'h1, 3'b001);
    drive(4'h0, 4'h1, 3'b001);
    // R4 / R5: operands ignored on unused codes, then back to a live code (R11)
    drive(4'hF, 4'hF, 3'b111);
    drive(4'hA, 4'h5, 3'b011);
    drive(4'hF, 4'hF, 3'b101);
    // exhaustive sweep, codes changing fastest so stale values would show
    for (int i = 0; i < 16; i++)
      for (int j = 0; j < 16; j++)
        for (int k = 0; k < 8; k++)
          drive(4'(i), 4'(j), 3'(k));
    wait (q.size() == 0);
    @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule